// File: doc/BRIEF.md
# Clock Mode and Standby Controller

This block decides which clock source feeds the CPU and the peripherals, and it drives the clock-gating enables for the low-power states. It has three run modes: PLL (a multiple of the oscillator), main (the oscillator divided by 2) and sub-clock. It has three standby states: sleep, watch and stop. The oscillators, the PLL, the watch timer and the voltage detector sit outside the block. The block sees them only as enables and as a tick input from the sub-clock source. Everything runs on one control clock, `clk`. The sub-clock is represented by `sub_src_tick` pulses, and the block divides those by 2 or by 4.

The controller is a single state machine with these states:
- `S_MAIN`, `S_PLL` and `S_SUB` are the run modes.
- `S_SWITCH` is a one-cycle gap in which every clock is gated off between two sources.
- `S_SLEEP`, `S_WATCH` and `S_STOP` are the standby states.
- `S_WAKE` waits for the sub-clock to settle after stop.

The transitions are:
- A run mode goes to `S_SWITCH` on a request for a different run mode.
- `S_SWITCH` goes to the requested run mode.
- A run mode goes to the requested standby state.
- `S_SLEEP` and `S_WATCH` return to the prior run mode on an enabled wake event.
- `S_STOP` goes to `S_WAKE` on an enabled wake event.
- `S_WAKE` goes to the prior run mode once settling ends.

A request for sub-clock mode made while settling is running is kept pending. It is carried out when the count finishes.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is active and right after it, the block is in main mode: `mode_stat`=0, `clk_sel`=1, `main_osc_en`=1, `pll_en`=0, and `settle_busy`=1.
- R2: The run modes drive these outputs:

  | Mode | `mode_stat` | `clk_sel` | `main_osc_en` | `pll_en` |
  |---|---|---|---|---|
  | main | 0 | 1 | 1 | 0 |
  | PLL | 1 | 2 | 1 | 1 |
  | sub | 2 | 3 | 0 | 0 |

  In all three, `cpu_clk_en`, `per_clk_en` and `watch_en` are 1. Request codes on `req_mode` are 0 main, 1 PLL, 2 sub, 4 sleep, 5 watch and 6 stop.
- R3: One sub-clock tick occurs every 2 pulses of `sub_src_tick`, or every 4 when `sub_div4`=1. `settle_busy` stays high for 2^SETTLE_LOG2 sub-clock ticks after reset and after each stop wake-up. With a pulse on every cycle, that is 2·2^SETTLE_LOG2 or 4·2^SETTLE_LOG2 cycles.
- R4: A sub-clock request made while `settle_busy`=1 leaves the mode unchanged. The switch begins in the cycle after `settle_busy` falls.
- R5: Every change between run modes spends exactly one cycle in the switch state (`mode_stat`=3). In that cycle `cpu_clk_en`=0, `per_clk_en`=0 and `clk_sel`=0.
- R6: These requests are ignored and the mode does not change:
  - a request for the run mode already active;
  - a request with code 3 or 7;
  - any request made while a sub-clock request is pending.
- R7: Sleep gates off only the CPU clock. `per_clk_en`=1, and `clk_sel` and the oscillator enables keep their run-mode values. `mode_stat` is 4, 5 or 6 for sleep entered from main, PLL or sub.
- R8: In watch (`mode_stat`=7), `main_osc_en`, `pll_en`, `cpu_clk_en` and `per_clk_en` are 0, `clk_sel`=0, and `watch_en`=1.
- R9: In stop (`mode_stat`=8), every enable is 0. An enabled wake event moves the block to the wake-settle state (`mode_stat`=9) with `settle_busy`=1 and the CPU and peripheral clocks still off. After settling, the block returns to the run mode it left.
- R10: A wake event counts only where the matching `wake_mask` bit is 1. An enabled wake event returns the block from sleep or watch to the run mode it left.
- R11: When `intermittent`=1 in a run mode, `cpu_clk_en` follows `bus_req` and `per_clk_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock |
| rst_n | input | 1 | active-low asynchronous reset (power-on) |
| sub_src_tick | input | 1 | one pulse per cycle of the sub-clock source |
| sub_div4 | input | 1 | 1: divide the sub-clock source by 4, 0: by 2 |
| req_valid | input | 1 | mode request strobe |
| req_mode | input | 3 | requested mode code |
| intermittent | input | 1 | CPU intermittent operation enable |
| bus_req | input | 1 | CPU bus access active |
| wake_evt | input | WAKE_N | wake event lines |
| wake_mask | input | WAKE_N | per-line wake enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | peripheral clock gate enable |
| watch_en | output | 1 | watch timer and voltage-detect clock enable |
| clk_sel | output | 2 | source select: 0 none, 1 main, 2 PLL, 3 sub |
| main_osc_en | output | 1 | main oscillator enable |
| pll_en | output | 1 | PLL enable |
| settle_busy | output | 1 | sub-clock settling count running |
| mode_stat | output | 4 | current state code |

## Verification
The hardest situation to reach is a sub-clock request arriving inside the settling window, followed by a second request that must be dropped while the first is still pending. The bench releases reset with the sub-clock source pulsing on every cycle. It makes both requests while counting the busy cycles, and then confirms that the switch starts exactly one cycle after busy falls. A second reset with the divide-by-4 option set checks the longer window. Stop wake-up is reached from PLL mode, so that the return to the remembered run mode can be seen after the restarted count.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [3:0] {
        S_MAIN   = 4'd0,
        S_PLL    = 4'd1,
        S_SUB    = 4'd2,
        S_SWITCH = 4'd3,
        S_SLEEP  = 4'd4,
        S_WATCH  = 4'd7,
        S_STOP   = 4'd8,
        S_WAKE   = 4'd9
    } state_t;

    typedef enum logic [1:0] {
        RUN_MAIN = 2'd0,
        RUN_PLL  = 2'd1,
        RUN_SUB  = 2'd2
    } run_t;

    localparam logic [2:0] REQ_MAIN  = 3'd0;
    localparam logic [2:0] REQ_PLL   = 3'd1;
    localparam logic [2:0] REQ_SUB   = 3'd2;
    localparam logic [2:0] REQ_SLEEP = 3'd4;
    localparam logic [2:0] REQ_WATCH = 3'd5;
    localparam logic [2:0] REQ_STOP  = 3'd6;

    localparam logic [1:0] SEL_NONE = 2'd0;

endpackage

// File: rtl/sub_divider.sv
module sub_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic src_tick,
    input  logic div4,
    output logic sub_tick
);
    logic [1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 2'd0;
        else if (src_tick)
            phase_q <= phase_q + 2'd1;
    end

    assign sub_tick = src_tick && (div4 ? (phase_q == 2'd3) : phase_q[0]);

endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
    parameter int SETTLE_LOG2 = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic busy
);
    localparam int CW = SETTLE_LOG2 + 1;

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (restart)
            count_q <= '0;
        else if (tick && busy)
            count_q <= count_q + CW'(1);
    end

    assign busy = ~count_q[CW-1];

    // R3
    settle_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !restart) |=> !busy);

    // R3
    settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> busy);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import clkmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_mode,
    input  logic       intermittent,
    input  logic       bus_req,
    input  logic       wake_hit,
    input  logic       settle_busy,
    output logic       settle_restart,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       watch_en,
    output logic [1:0] clk_sel,
    output logic       main_osc_en,
    output logic       pll_en,
    output logic [3:0] mode_stat
);
    state_t state_q, state_n;
    run_t   run_q, run_n;
    run_t   tgt_q, tgt_n;
    logic   pend_q, pend_n;

    function automatic state_t run_state(input run_t r);
        unique case (r)
            RUN_PLL: return S_PLL;
            RUN_SUB: return S_SUB;
            default: return S_MAIN;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_MAIN;
            run_q   <= RUN_MAIN;
            tgt_q   <= RUN_MAIN;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
            tgt_q   <= tgt_n;
            pend_q  <= pend_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        tgt_n   = tgt_q;
        pend_n  = pend_q;
        unique case (state_q)
            S_MAIN, S_PLL, S_SUB: begin
                if (pend_q) begin
                    if (!settle_busy) begin
                        state_n = S_SWITCH;
                        tgt_n   = RUN_SUB;
                        pend_n  = 1'b0;
                    end
                end else if (req_valid) begin
                    unique case (req_mode)
                        REQ_MAIN, REQ_PLL, REQ_SUB: begin
                            if (req_mode[1:0] != run_q) begin
                                if (req_mode == REQ_SUB && settle_busy) begin
                                    pend_n = 1'b1;
                                end else begin
                                    state_n = S_SWITCH;
                                    tgt_n   = run_t'(req_mode[1:0]);
                                end
                            end
                        end
                        REQ_SLEEP: state_n = S_SLEEP;
                        REQ_WATCH: state_n = S_WATCH;
                        REQ_STOP:  state_n = S_STOP;
                        default:   state_n = state_q;
                    endcase
                end
            end
            S_SWITCH: begin
                state_n = run_state(tgt_q);
                run_n   = tgt_q;
            end
            S_SLEEP, S_WATCH: begin
                if (wake_hit)
                    state_n = run_state(run_q);
            end
            S_STOP: begin
                if (wake_hit)
                    state_n = S_WAKE;
            end
            S_WAKE: begin
                if (!settle_busy)
                    state_n = run_state(run_q);
            end
            default: state_n = S_MAIN;
        endcase
    end

    // outputs
    always_comb begin
        logic in_run;
        in_run         = (state_q == S_MAIN) || (state_q == S_PLL) || (state_q == S_SUB);
        settle_restart = (state_q == S_STOP) && wake_hit;
        cpu_clk_en     = 1'b0;
        per_clk_en     = 1'b0;
        watch_en       = 1'b1;
        clk_sel        = SEL_NONE;
        main_osc_en    = 1'b0;
        pll_en         = 1'b0;
        mode_stat      = state_q;
        unique case (state_q)
            S_MAIN, S_PLL, S_SUB, S_SLEEP: begin
                cpu_clk_en  = in_run && (!intermittent || bus_req);
                per_clk_en  = 1'b1;
                clk_sel     = 2'(run_q) + 2'd1;
                main_osc_en = (run_q != RUN_SUB);
                pll_en      = (run_q == RUN_PLL);
                if (state_q == S_SLEEP)
                    mode_stat = 4'd4 + 4'(run_q);
            end
            S_SWITCH: begin
                main_osc_en = (run_q != RUN_SUB) || (tgt_q != RUN_SUB);
                pll_en      = (run_q == RUN_PLL) || (tgt_q == RUN_PLL);
            end
            S_WATCH: begin
                watch_en = 1'b1;
            end
            S_STOP: begin
                watch_en = 1'b0;
            end
            S_WAKE: begin
                watch_en    = 1'b0;
                main_osc_en = (run_q != RUN_SUB);
                pll_en      = (run_q == RUN_PLL);
            end
            default: watch_en = 1'b1;
        endcase
    end

    // R5
    switch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SWITCH) |=> (state_q != S_SWITCH));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && settle_busy && state_q != S_SWITCH) |=> $stable(state_q));

    // R9
    stop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && wake_hit) |=> (state_q == S_WAKE && settle_busy));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SLEEP && !wake_hit) |=> (state_q == S_SLEEP));

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
    parameter int SETTLE_LOG2 = 14,
    parameter int WAKE_N      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_src_tick,
    input  logic              sub_div4,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              intermittent,
    input  logic              bus_req,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic [WAKE_N-1:0] wake_mask,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              watch_en,
    output logic [1:0]        clk_sel,
    output logic              main_osc_en,
    output logic              pll_en,
    output logic              settle_busy,
    output logic [3:0]        mode_stat
);
    logic sub_tick;
    logic restart;
    logic wake_hit;

    assign wake_hit = |(wake_evt & wake_mask);

    sub_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (sub_src_tick),
        .div4     (sub_div4),
        .sub_tick (sub_tick)
    );

    settle_counter #(.SETTLE_LOG2(SETTLE_LOG2)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (sub_tick),
        .busy    (settle_busy)
    );

    mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_mode       (req_mode),
        .intermittent   (intermittent),
        .bus_req        (bus_req),
        .wake_hit       (wake_hit),
        .settle_busy    (settle_busy),
        .settle_restart (restart),
        .cpu_clk_en     (cpu_clk_en),
        .per_clk_en     (per_clk_en),
        .watch_en       (watch_en),
        .clk_sel        (clk_sel),
        .main_osc_en    (main_osc_en),
        .pll_en         (pll_en),
        .mode_stat      (mode_stat)
    );

    // R8
    watch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 4'd7) |-> (!per_clk_en && !cpu_clk_en && !main_osc_en && watch_en));

endmodule

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
    localparam int LOG2 = 4;
    localparam int WN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sub_src_tick = 1'b1, sub_div4 = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic intermittent = 1'b0, bus_req = 1'b0;
    logic [WN-1:0] wake_evt = '0, wake_mask = '0;
    logic cpu_clk_en, per_clk_en, watch_en, main_osc_en, pll_en, settle_busy;
    logic [1:0] clk_sel;
    logic [3:0] mode_stat;

    int total = 0, bad = 0;
    int n;

    always #5 clk = ~clk;

    clkmode_ctrl #(.SETTLE_LOG2(LOG2), .WAKE_N(WN)) u0 (
        .clk(clk), .rst_n(rst_n), .sub_src_tick(sub_src_tick), .sub_div4(sub_div4),
        .req_valid(req_valid), .req_mode(req_mode), .intermittent(intermittent),
        .bus_req(bus_req), .wake_evt(wake_evt), .wake_mask(wake_mask),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .watch_en(watch_en),
        .clk_sel(clk_sel), .main_osc_en(main_osc_en), .pll_en(pll_en),
        .settle_busy(settle_busy), .mode_stat(mode_stat)
    );

    // {req_mode, stat after 1 cycle, stat after 2 cycles, {cpu,per,main,pll,watch,sel}}
    localparam logic [17:0] VEC [8] = '{
        {3'd0, 4'd3, 4'd0, 7'b1110101},
        {3'd1, 4'd3, 4'd1, 7'b1111110},
        {3'd1, 4'd1, 4'd1, 7'b1111110},
        {3'd3, 4'd1, 4'd1, 7'b1111110},
        {3'd2, 4'd3, 4'd2, 7'b1100111},
        {3'd7, 4'd2, 4'd2, 7'b1100111},
        {3'd0, 4'd3, 4'd0, 7'b1110101},
        {3'd1, 4'd3, 4'd1, 7'b1111110}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic request(input logic [2:0] m);
        req_valid = 1'b1;
        req_mode  = m;
        step();
        req_valid = 1'b0;
    endtask

    task automatic wake(input logic [WN-1:0] e);
        wake_evt = e;
        step();
        wake_evt = '0;
    endtask

    function automatic int flags();
        return {cpu_clk_en, per_clk_en, main_osc_en, pll_en, watch_en, clk_sel};
    endfunction

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        step();
        check("R1 stat", mode_stat, 0);
        check("R1 flags", {clk_sel, main_osc_en, pll_en, settle_busy}, {2'd1, 1'b1, 1'b0, 1'b1});
        rst_n = 1'b1;
        // R3, R4, R6: pending sub request during settling
        n = 0;
        while (settle_busy && n < 500) begin
            if (n == 2) begin req_valid = 1'b1; req_mode = 3'd2; end
            if (n == 3) req_valid = 1'b0;
            if (n == 5) begin req_valid = 1'b1; req_mode = 3'd1; end
            if (n == 6) req_valid = 1'b0;
            if (n == 8) check("R4 held in main", mode_stat, 0);
            n++;
            step();
        end
        check("R3 busy cycles div2", n, 2 * (1 << LOG2));
        check("R4 still main at busy fall", mode_stat, 0);
        step();
        check("R4 switch after settle", mode_stat, 3);
        check("R5 gated in switch", {cpu_clk_en, per_clk_en, clk_sel}, 0);
        step();
        check("R6 pending sub wins, pll ignored", mode_stat, 2);
        check("R2 sub flags", flags(), 7'b1100111);

        // table walk: R2, R5, R6
        foreach (VEC[i]) begin
            request(VEC[i][17:15]);
            check($sformatf("R6 vec%0d stat1", i), mode_stat, VEC[i][14:11]);
            if (VEC[i][14:11] == 4'd3)
                check($sformatf("R5 vec%0d gated", i), {cpu_clk_en, per_clk_en, clk_sel}, 0);
            step();
            check($sformatf("R2 vec%0d stat2", i), mode_stat, VEC[i][10:7]);
            check($sformatf("R2 vec%0d flags", i), flags(), VEC[i][6:0]);
        end

        // R11 intermittent in PLL
        intermittent = 1'b1;
        bus_req = 1'b0;
        step();
        check("R11 cpu off idle", {cpu_clk_en, per_clk_en}, 2'b01);
        bus_req = 1'b1;
        step();
        check("R11 cpu on access", {cpu_clk_en, per_clk_en}, 2'b11);
        intermittent = 1'b0;
        bus_req = 1'b0;

        // R7 sleep from PLL, R10 masking
        request(3'd4);
        check("R7 sleep stat", mode_stat, 5);
        check("R7 sleep flags", flags(), 7'b0111110);
        wake_mask = 4'b0010;
        wake(4'b0001);
        check("R10 masked wake ignored", mode_stat, 5);
        wake(4'b0010);
        check("R10 wake to pll", mode_stat, 1);

        // R8 watch
        request(3'd5);
        check("R8 watch stat", mode_stat, 7);
        check("R8 watch flags", flags(), 7'b0000100);
        wake(4'b0010);
        check("R10 watch wake", mode_stat, 1);

        // R9 stop and wake settle
        request(3'd6);
        check("R9 stop stat", mode_stat, 8);
        check("R9 stop flags", flags(), 0);
        wake_evt = 4'b0010;
        step();
        wake_evt = '0;
        check("R9 wake state", mode_stat, 9);
        check("R9 wake gated busy", {cpu_clk_en, per_clk_en, settle_busy}, 3'b001);
        n = 0;
        while (settle_busy && n < 500) begin
            n++;
            step();
        end
        check("R3 restart window", (n >= 2 * (1 << LOG2) - 2 && n <= 2 * (1 << LOG2)) ? 1 : 0, 1);
        step();
        check("R9 back to pll", mode_stat, 1);

        // R7 sleep from sub
        request(3'd2);
        step();
        request(3'd4);
        check("R7 sleep from sub", mode_stat, 6);
        check("R7 sub sleep flags", flags(), 7'b0100111);
        wake(4'b0010);

        // R3 divide-by-4 window after a new reset
        rst_n = 1'b0;
        sub_div4 = 1'b1;
        step();
        check("R1 reset again", mode_stat, 0);
        rst_n = 1'b1;
        n = 0;
        while (settle_busy && n < 500) begin
            n++;
            step();
        end
        check("R3 busy cycles div4", n, 4 * (1 << LOG2));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule